// File: doc/BRIEF.md
# SMBus Slave Register Controller

This block is a slave-only SMBus engine that runs on a fast system clock. It oversamples the serial clock and data lines, finds START and STOP conditions, and serves the write-byte, read-byte, send-byte and receive-byte transfers. An 8-bit command pointer selects an entry in a small register file. The file holds a normal set and a suspend set of three registers each: an output-drive value, a rising-edge interrupt mask and a falling-edge interrupt mask. The pointer also reaches a live view of the pin vector, a fixed identity byte and two one-shot commands.

The slave answers its own 7-bit address, which is an input. While an interrupt is pending it also answers the alert response address. In that case it sends back its own address and uses bit-level arbitration, so that the lowest address among the responders wins. Register updates and command pulses take effect after the falling SCL edge of the acknowledge clock that ends the relevant byte. A byte cut short by START or STOP is discarded. The slave only ever pulls SDA low, through an active-high output-enable.

Top module: `smbx_reg_slave`

## Requirements
- R1: After reset all six registers hold their init values (default FFh), the pointer is 00h, `sda_oe` is low and no strobe is active.
- R2: A write-byte with command 00h–05h stores the data byte into that register only and pulses `wr_stb` for one cycle. The slave acknowledges the address, the command and the data byte. The codes map as 00h normal drive, 01h normal rise mask, 02h normal fall mask, and 03h/04h/05h the suspend copies in the same order.
- R3: A write-byte whose command is any code other than 00h–05h stores its data byte into register 00h.
- R4: Command code 07h gives one `resample_stb` pulse. Code 08h gives one `soft_rst_stb` pulse and returns all six registers to their init values. Both pulses occur whether the code arrives as a send-byte or as the command of a longer transfer. A soft reset leaves the pointer holding 08h.
- R5: A START or STOP that arrives before a data or command byte is complete changes no register and gives no write strobe.
- R6: A read-byte returns the selected entry. For 00h–05h this is the stored value. For 06h it is `pin_i`, sampled at the falling SCL edge of the acknowledge after the address-read byte, together with one `pin_smp_stb` pulse. FEh returns 4Dh and every other code returns 00h.
- R7: A receive-byte returns the entry chosen by the most recent command byte, which is 00h after reset.
- R8: A transfer to any other address is not acknowledged, never drives SDA and changes no register.
- R9: While `alert_pend` is high, a read to address 0001100 (byte 19h) is acknowledged and returns {own_addr, 0} MSB first, followed by one `alert_done` pulse. While `alert_pend` is low the same byte is not acknowledged.
- R10: If SDA is low during a transmitted bit in which the slave has released it, the slave drives nothing more for the rest of that byte and gives no `alert_done`.
- R11: The slave starts pulling SDA low only while SCL is low. It releases SDA after the acknowledge slot of a read byte, so SDA is never driven between transfers.
- R12: Every strobe lasts exactly one clock, and at most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SMBus clock line |
| sda_i | input | 1 | Sensed SMBus data line |
| own_addr | input | 7 | Slave address of this device |
| pin_i | input | 8 | Live pin levels offered for readback |
| alert_pend | input | 1 | An interrupt is waiting to be claimed |
| sda_oe | output | 1 | High pulls SDA low |
| norm_drive | output | 8 | Normal-set output drive register (00h) |
| norm_rise_mask | output | 8 | Normal-set rising-edge mask (01h) |
| norm_fall_mask | output | 8 | Normal-set falling-edge mask (02h) |
| susp_drive | output | 8 | Suspend-set output drive register (03h) |
| susp_rise_mask | output | 8 | Suspend-set rising-edge mask (04h) |
| susp_fall_mask | output | 8 | Suspend-set falling-edge mask (05h) |
| wr_stb | output | 1 | One-cycle pulse when a register is written |
| resample_stb | output | 1 | One-cycle address-resample command |
| soft_rst_stb | output | 1 | One-cycle soft-reset command |
| pin_smp_stb | output | 1 | One-cycle pulse when pin levels are captured |
| alert_done | output | 1 | One-cycle pulse when the alert response is won |

## Verification
A wrong stored value is visible on the six parallel register outputs as soon as a transfer ends, and the bench compares them with its model on every clock between transfers. A wrong pointer or a wrong read-mux entry shows in the first data bit the master clocks in on the next read or receive. A miscounted bit or a wrong state shows as an acknowledge in the wrong slot, or a missing one, within one SCL period. A broken arbitration latch corrupts the low bits of the alert byte as seen on the wired line.

// File: rtl/smbx_pkg.sv
// Shared constants and state type for the SMBus slave register controller.
// Assumes 8-bit command codes and 8-bit register data.
package smbx_pkg;
    localparam int CW = 8;

    localparam logic [CW-1:0] CMD_PINS     = 8'h06;
    localparam logic [CW-1:0] CMD_RESAMPLE = 8'h07;
    localparam logic [CW-1:0] CMD_SOFTRST  = 8'h08;
    localparam logic [CW-1:0] CMD_IDENT    = 8'hFE;
    localparam logic [7:0]    IDENT_BYTE   = 8'h4D;
    localparam logic [6:0]    ALERT_ADDR   = 7'b0001100;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_DATA, ST_DATA_ACK, ST_TX, ST_TX_ACK, ST_WAIT
    } bus_st_e;
endpackage

// File: rtl/smbx_glitch_filter.sv
// Line conditioner: a synchronizer chain followed by a majority vote over a
// short sample window. Assumes the line idles high, so all stages reset to 1.
module smbx_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   win_q;

    // Resynchronize, shift the vote window and register the majority result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            win_q  <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            clean  <= ($countones(win_q) > (VOTE_TAPS / 2));
        end
    end
endmodule

// File: rtl/smbx_regfile.sv
// Register file: six writable registers (normal and suspend sets of drive,
// rise mask, fall mask) plus a read mux for pins and identity byte.
// Assumes the write port gets one-cycle strobes; a soft reset has priority.
module smbx_regfile
    import smbx_pkg::*;
#(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] DRIVE_INIT = '1,
    parameter logic [DW-1:0] MASK_INIT  = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [CW-1:0]      wr_code,
    input  logic [DW-1:0]      wr_data,
    input  logic               soft_rst,
    input  logic [CW-1:0]      rd_code,
    input  logic [DW-1:0]      pins,
    output logic [DW-1:0]      rd_data,
    output logic [6*DW-1:0]    regs_o
);
    localparam int NREG = 6;
    localparam int IW   = $clog2(NREG);

    logic [DW-1:0] bank [NREG];
    logic [IW-1:0] wr_idx;

    // Steer every non-writable code to register 0.
    always_comb begin
        wr_idx = '0;
        if (wr_code < CW'(NREG)) wr_idx = wr_code[IW-1:0];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] INIT = ((g % 3) == 0) ? DRIVE_INIT : MASK_INIT;
        logic [DW-1:0] q;

        // Hold one register; reload init on reset or soft reset.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) q <= INIT;
            else if (wr_stb && wr_idx == IW'(g)) q <= wr_data;
        end

        assign bank[g]             = q;
        assign regs_o[g*DW +: DW]  = q;

        assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (q == INIT));
    end

    // Select the read value for the current pointer.
    always_comb begin
        rd_data = '0;
        if (rd_code < CW'(NREG))     rd_data = bank[rd_code[IW-1:0]];
        else if (rd_code == CMD_PINS)  rd_data = pins;
        else if (rd_code == CMD_IDENT) rd_data = DW'(IDENT_BYTE);
    end

    assert_steer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !soft_rst && wr_code >= CW'(NREG)) |=> (bank[0] == $past(wr_data)));
endmodule

// File: rtl/smbx_reg_slave.sv
// SMBus slave engine: filters SCL/SDA, detects START/STOP, runs the byte
// protocol, acknowledges, transmits read data and alert-response address
// with arbitration, and issues register strobes and command pulses after
// the falling SCL edge of each acknowledge clock. Assumes clk is many times
// faster than SCL and that SDA is driven only by pulling low (sda_oe).
module smbx_reg_slave
    import smbx_pkg::*;
#(
    parameter int             DW          = 8,
    parameter logic [DW-1:0]  DRIVE_INIT  = '1,
    parameter logic [DW-1:0]  MASK_INIT   = '1,
    parameter int             SYNC_STAGES = 2,
    parameter int             VOTE_TAPS   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [DW-2:0] own_addr,
    input  logic [DW-1:0] pin_i,
    input  logic          alert_pend,
    output logic          sda_oe,
    output logic [DW-1:0] norm_drive,
    output logic [DW-1:0] norm_rise_mask,
    output logic [DW-1:0] norm_fall_mask,
    output logic [DW-1:0] susp_drive,
    output logic [DW-1:0] susp_rise_mask,
    output logic [DW-1:0] susp_fall_mask,
    output logic          wr_stb,
    output logic          resample_stb,
    output logic          soft_rst_stb,
    output logic          pin_smp_stb,
    output logic          alert_done
);
    localparam int BITW = $clog2(DW + 1);

    logic scl_f, sda_f, scl_q, sda_q;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    bus_st_e st;
    logic [BITW-1:0] bitcnt;
    logic [DW-1:0]   shreg, rd_data, tx_byte;
    logic [CW-1:0]   ptr;
    logic            is_read, alert_sel, lost;
    logic            own_hit, alert_hit;
    logic [6*DW-1:0] regs;

    smbx_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));
    smbx_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

    smbx_regfile #(.DW(DW), .DRIVE_INIT(DRIVE_INIT), .MASK_INIT(MASK_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_code(ptr), .wr_data(shreg),
        .soft_rst(soft_rst_stb), .rd_code(ptr), .pins(pin_i), .rd_data(rd_data),
        .regs_o(regs));

    assign norm_drive     = regs[0*DW +: DW];
    assign norm_rise_mask = regs[1*DW +: DW];
    assign norm_fall_mask = regs[2*DW +: DW];
    assign susp_drive     = regs[3*DW +: DW];
    assign susp_rise_mask = regs[4*DW +: DW];
    assign susp_fall_mask = regs[5*DW +: DW];

    // Delay the filtered lines by one clock for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Classify line events and address matches.
    always_comb begin
        scl_rise  = scl_f && !scl_q;
        scl_fall  = !scl_f && scl_q;
        start_ev  = scl_f && scl_q && sda_q && !sda_f;
        stop_ev   = scl_f && scl_q && !sda_q && sda_f;
        own_hit   = (shreg[DW-1:1] == own_addr);
        alert_hit = (shreg[DW-1:1] == ALERT_ADDR) && shreg[0] && alert_pend;
        tx_byte   = alert_sel ? {own_addr, 1'b0} : rd_data;
    end

    // Byte-level protocol engine with acknowledge and transmit handling.
    always_ff @(posedge clk) begin
        wr_stb       <= 1'b0;
        resample_stb <= 1'b0;
        soft_rst_stb <= 1'b0;
        pin_smp_stb  <= 1'b0;
        alert_done   <= 1'b0;
        if (!rst_n) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            alert_sel <= 1'b0;
            lost      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (start_ev) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            lost   <= 1'b0;
        end else if (stop_ev) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[DW-2:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == BITW'(DW)) begin
                        if (st == ST_ADDR) begin
                            if (own_hit || alert_hit) begin
                                sda_oe    <= 1'b1;
                                is_read   <= shreg[0];
                                alert_sel <= !own_hit;
                                st        <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            st     <= (st == ST_CMD) ? ST_CMD_ACK : ST_DATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    if (is_read) begin
                        shreg       <= tx_byte;
                        sda_oe      <= !tx_byte[DW-1];
                        pin_smp_stb <= !alert_sel && (ptr == CMD_PINS);
                        st          <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_CMD;
                    end
                end
                ST_CMD_ACK: if (scl_fall) begin
                    sda_oe       <= 1'b0;
                    ptr          <= shreg;
                    resample_stb <= (shreg == CMD_RESAMPLE);
                    soft_rst_stb <= (shreg == CMD_SOFTRST);
                    bitcnt       <= '0;
                    st           <= ST_DATA;
                end
                ST_DATA_ACK: if (scl_fall) begin
                    sda_oe <= 1'b0;
                    wr_stb <= 1'b1;
                    st     <= ST_WAIT;
                end
                ST_TX: begin
                    if (scl_rise && !sda_oe && !sda_f) lost <= 1'b1;
                    if (scl_fall) begin
                        if (bitcnt == BITW'(DW - 1)) begin
                            sda_oe <= 1'b0;
                            st     <= ST_TX_ACK;
                        end else begin
                            shreg  <= {shreg[DW-2:0], 1'b0};
                            sda_oe <= !lost && !shreg[DW-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: if (scl_fall) begin
                    alert_done <= alert_sel && !lost;
                    st         <= ST_WAIT;
                end
                default: ;
            endcase
        end
    end

    assert_pulse_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_pulse_alert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        alert_done |=> !alert_done);
    assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, resample_stb, soft_rst_stb, pin_smp_stb, alert_done}));
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);
    assert_lost_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && lost && !scl_f) |=> !sda_oe);
endmodule

// File: tb/smbx_reg_slave_tb.sv
module smbx_reg_slave_tb;
    localparam int HALF = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, comp_sda = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic [7:0] pin_i = 8'h00;
    logic       alert_pend = 1'b0;
    logic       sda_oe, sda_line;
    logic [7:0] nd, nr, nf, sd, sr, sf;
    logic       wr_stb, resample_stb, soft_rst_stb, pin_smp_stb, alert_done;

    assign sda_line = m_sda & ~sda_oe & comp_sda;

    smbx_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .own_addr(own_addr), .pin_i(pin_i), .alert_pend(alert_pend),
        .sda_oe(sda_oe), .norm_drive(nd), .norm_rise_mask(nr), .norm_fall_mask(nf),
        .susp_drive(sd), .susp_rise_mask(sr), .susp_fall_mask(sf),
        .wr_stb(wr_stb), .resample_stb(resample_stb), .soft_rst_stb(soft_rst_stb),
        .pin_smp_stb(pin_smp_stb), .alert_done(alert_done));

    int vec = 0, bad = 0;
    logic settle = 1'b1;
    logic [7:0] mdl [6];
    logic [7:0] mptr = 8'h00;
    int c_wr = 0, c_rs = 0, c_sr = 0, c_ps = 0, c_ad = 0, c_oe = 0;
    int b_wr, b_rs, b_sr, b_ps, b_ad, b_oe;

    // Cumulative strobe high-cycle counters.
    always @(posedge clk) begin
        c_wr += int'(wr_stb);       c_rs += int'(resample_stb);
        c_sr += int'(soft_rst_stb); c_ps += int'(pin_smp_stb);
        c_ad += int'(alert_done);   c_oe += int'(sda_oe);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] got(input int i);
        case (i)
            0: got = nd; 1: got = nr; 2: got = nf;
            3: got = sd; 4: got = sr; default: got = sf;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        if (p < 8'd6)        exp_rd = mdl[p[2:0]];
        else if (p == 8'h06) exp_rd = pin_i;
        else if (p == 8'hFE) exp_rd = 8'h4D;
        else                 exp_rd = 8'h00;
    endfunction

    // Per-clock comparison of the register outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !settle) begin
            for (int i = 0; i < 6; i++) chk("R2 register vs model", got(i), mdl[i]);
            chk("R11 bus idle drive", sda_oe, 1'b0);
        end
    end

    task automatic hp(); repeat (HALF) @(negedge clk); endtask
    task automatic bstart(); m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; endtask
    task automatic bstop(); m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp(); endtask
    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; hp(); m_scl = 1'b1; hp(); s = sda_line; m_scl = 1'b0;
    endtask
    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask
    task automatic rbyte(input logic mack, input logic [7:0] comp, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            comp_sda = comp[i]; clk_bit(1'b1, s); b[i] = s;
        end
        comp_sda = 1'b1;
        clk_bit(!mack, s);
    endtask

    task automatic xbegin();
        settle = 1'b1;
        b_wr = c_wr; b_rs = c_rs; b_sr = c_sr; b_ps = c_ps; b_ad = c_ad; b_oe = c_oe;
    endtask
    task automatic xend(); repeat (12) @(negedge clk); endtask

    task automatic model_cmd(input logic [7:0] cmd);
        mptr = cmd;
        if (cmd == 8'h08) for (int i = 0; i < 6; i++) mdl[i] = 8'hFF;
    endtask

    task automatic wr_xfer(input logic [7:0] cmd, input logic [7:0] data);
        logic a0, a1, a2;
        xbegin();
        bstart(); wbyte({own_addr, 1'b0}, a0); wbyte(cmd, a1); wbyte(data, a2); bstop(); xend();
        chk("R2 ack addr/cmd/data", {a0, a1, a2}, 3'b111);
        chk("R2 write strobe one cycle", c_wr - b_wr, 1);
        chk("R4 resample pulses", c_rs - b_rs, (cmd == 8'h07) ? 1 : 0);
        chk("R4 soft reset pulses", c_sr - b_sr, (cmd == 8'h08) ? 1 : 0);
        model_cmd(cmd);
        if (cmd < 8'd6) mdl[cmd[2:0]] = data; else mdl[0] = data;  // R3 steering
        settle = 1'b0;
    endtask

    task automatic send_xfer(input logic [7:0] cmd);
        logic a0, a1;
        xbegin();
        bstart(); wbyte({own_addr, 1'b0}, a0); wbyte(cmd, a1); bstop(); xend();
        chk("R4 send-byte acks", {a0, a1}, 2'b11);
        chk("R4 resample pulses", c_rs - b_rs, (cmd == 8'h07) ? 1 : 0);
        chk("R4 soft reset pulses", c_sr - b_sr, (cmd == 8'h08) ? 1 : 0);
        chk("R4 no write strobe", c_wr - b_wr, 0);
        model_cmd(cmd);
        settle = 1'b0;
    endtask

    task automatic rd_xfer(input logic [7:0] cmd, input string tag);
        logic a0, a1, a2;
        logic [7:0] v, e;
        xbegin();
        bstart(); wbyte({own_addr, 1'b0}, a0); wbyte(cmd, a1);
        bstart(); wbyte({own_addr, 1'b1}, a2);
        model_cmd(cmd);
        e = exp_rd(cmd);
        rbyte(1'b0, 8'hFF, v); bstop(); xend();
        chk({tag, " read-byte acks"}, {a0, a1, a2}, 3'b111);
        chk({tag, " read-byte value"}, v, e);
        chk("R6 pin strobe count", c_ps - b_ps, (cmd == 8'h06) ? 1 : 0);
        chk("R11 released after read", sda_oe, 1'b0);
        settle = 1'b0;
    endtask

    task automatic rcv_xfer(input string tag);
        logic a0;
        logic [7:0] v, e;
        xbegin();
        e = exp_rd(mptr);
        bstart(); wbyte({own_addr, 1'b1}, a0); rbyte(1'b0, 8'hFF, v); bstop(); xend();
        chk({tag, " receive ack"}, a0, 1'b1);
        chk({tag, " receive value"}, v, e);
        settle = 1'b0;
    endtask

    task automatic alert_xfer(input logic [7:0] comp, input logic exp_ack,
                              input logic [7:0] exp_v, input int exp_done, input string tag);
        logic a0;
        logic [7:0] v;
        xbegin();
        bstart(); wbyte(8'h19, a0);
        if (a0) rbyte(1'b0, comp, v);
        bstop(); xend();
        chk({tag, " alert ack"}, a0, exp_ack);
        if (exp_ack) chk({tag, " alert byte"}, v, exp_v);
        chk({tag, " alert_done pulses"}, c_ad - b_ad, exp_done);
        settle = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic s, a0, a1;
        for (int i = 0; i < 6; i++) mdl[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 6; i++) chk("R1 init value", got(i), 8'hFF);
        chk("R1 sda released", sda_oe, 1'b0);
        chk("R1 strobes idle", {wr_stb, resample_stb, soft_rst_stb, pin_smp_stb, alert_done}, 5'b0);
        settle = 1'b0;
        hp();
        rcv_xfer("R7 pointer 00h after reset");

        // R2: distinct values into each writable register, read back (R6)
        for (int i = 0; i < 6; i++) wr_xfer(8'(i), 8'(8'h21 + i * 8'h13));
        for (int i = 0; i < 6; i++) rd_xfer(8'(i), "R6");

        // R3: non-writable codes steer into 00h; R4 side-effect of 07h
        wr_xfer(8'h06, 8'h5A);
        wr_xfer(8'hFE, 8'hA7);
        wr_xfer(8'h07, 8'h0F);
        rd_xfer(8'h00, "R3");

        // R6: identity, pins, unknown code
        rd_xfer(8'hFE, "R6 ident");
        pin_i = 8'h96;
        rd_xfer(8'h06, "R6 pins");
        pin_i = 8'h21;
        rcv_xfer("R7 pointer kept on pins");
        rd_xfer(8'h09, "R6 unknown code");

        // R4: one-shot commands; pointer survives the soft reset
        send_xfer(8'h07);
        wr_xfer(8'h04, 8'h3C);
        send_xfer(8'h08);
        rcv_xfer("R4 pointer holds 08h");

        // R5: aborts mid data byte (STOP and START) and mid command byte
        wr_xfer(8'h02, 8'h66);
        xbegin();
        bstart(); wbyte({own_addr, 1'b0}, a0); wbyte(8'h02, a1);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bstop(); xend();
        chk("R5 STOP abort no write", c_wr - b_wr, 0);
        bstart(); wbyte({own_addr, 1'b0}, a0); wbyte(8'h02, a1);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
        bstart(); bstop(); xend();
        chk("R5 START abort no write", c_wr - b_wr, 0);
        bstart(); wbyte({own_addr, 1'b0}, a0);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        bstop(); xend();
        mptr = 8'h02;
        settle = 1'b0;
        rcv_xfer("R5 pointer and data intact");

        // R8: foreign address
        xbegin();
        bstart(); wbyte(8'h22, a0); wbyte(8'h01, a1); wbyte(8'h00, s); bstop(); xend();
        chk("R8 foreign address not acked", a0, 1'b0);
        chk("R8 SDA never driven", c_oe - b_oe, 0);
        chk("R8 no write strobe", c_wr - b_wr, 0);
        settle = 1'b0;

        // R9 / R10: alert response
        alert_xfer(8'hFF, 1'b0, 8'h00, 0, "R9 no pending");
        alert_pend = 1'b1;
        alert_xfer(8'hFF, 1'b1, 8'h54, 1, "R9 pending");
        alert_xfer(8'h4E, 1'b1, 8'h4E, 0, "R10 arbitration lost");
        alert_pend = 1'b0;
        rcv_xfer("R7 pointer after alert");

        report();
        $finish;
    end
endmodule